// File: doc/BRIEF.md
# Instruction count debug trigger

This block provides a bank of instruction-count debug triggers. Each slot keeps its configuration and its remaining count together in one 32-bit control word. That word is written and read through a CSR-style port. A slot counts down once for each retired instruction, but only when two conditions hold. The current privilege level, together with the virtualization flag, must be one the slot enables. The slot's optional context qualifier must also agree with the machine context value.

When a decrement takes the count from one to zero, the slot raises a breakpoint request for one cycle. A count of zero leaves the slot dormant until software loads a new count. The live control word, including the current count, is visible on the output at all times.

Top module: `icnt_trigger`

## Requirements
- R1: After reset every slot's control word reads 0x30000000: type field [31:28] = 3, every other bit zero. The context qualifier is off, and fire_o and bp_req_o are low.
- R2: A control write (csr_reg_i = 1) is legalized before storage. The type field [31:28] is forced to 3. Only bits 26, 25, 23:10, 9, 7 and 6 keep the written value, and every other bit reads zero. Writing 0xFFFFFFFF therefore reads back 0x36FFFEC0.
- R3: Outside virtualization (virt_i = 0), a retirement decrements the count in bits [23:10] when control bit 6+priv_i is set. That bit is 6 for priv 0, 7 for priv 1 and 9 for priv 3.
- R4: Under virtualization (virt_i = 1), the enable bit is 25+priv_i, and only priv 0 and 1 can count. The non-virtualized enable bits have no effect in this state.
- R5: A retirement in a privilege mode the slot does not enable leaves the count unchanged. A cycle without retirement also leaves it unchanged.
- R6: A slot whose count is zero never decrements and never fires.
- R7: When a decrement takes the count from 1 to 0, fire_o[slot] and bp_req_o go high for exactly one cycle. They change on the same clock edge as the count.
- R8: Context qualifier (csr_reg_i = 3). Bits [31:26] hold a 6-bit match value, and bits [25:23] hold the select field. The select field is legalized to 4 when bit 25 is set and to 0 otherwise. With select 4, counting also requires mcontext_i to equal the match value.
- R9: A write with csr_reg_i = 2 has no effect on any slot. A retirement in the same cycle is still counted.
- R10: A control write to a slot in the same cycle as a retirement takes priority. The written count is stored, and that retirement is not counted for that slot.
- R11: The control word output shows the decremented count on the clock edge of the retirement, with no further lag.
- R12: Slots count independently. A control write to one slot does not stop another slot from counting the same retirement.
- R13: A write whose csr_slot_i is not below NUM_SLOTS changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization active |
| mcontext_i | input | 6 | Machine context value for the qualifier |
| csr_we_i | input | 1 | CSR write strobe |
| csr_slot_i | input | SLOT_W | Slot addressed by the write |
| csr_reg_i | input | 2 | Register selected: 1 control, 2 address (ignored), 3 context |
| csr_wdata_i | input | 32 | Write data |
| tdata1_o | output | NUM_SLOTS*32 | Live control word of every slot, slot 0 in the low bits |
| fire_o | output | NUM_SLOTS | Per-slot one-cycle fire pulse |
| bp_req_o | output | 1 | Breakpoint exception request |

## Verification
The bench builds the block with NUM_SLOTS = 3, so SLOT_W is 2. A slot index of 3 is then both encodable and out of range, which brings the ignored-write case (R13) within reach. Three slots also allow one slot to fire while another is still counting and a third sits dormant at zero. This exposes any cross-slot leakage of write priority, decrement or fire pulses.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int unsigned TD_W     = 32;
  localparam int unsigned TYPE_LO  = 28;
  localparam logic [3:0]  TYPE_ICNT = 4'd3;
  localparam int unsigned CNT_LO   = 10;
  localparam int unsigned CNT_W    = 14;
  localparam int unsigned NV_EN_LO = 6;
  localparam int unsigned V_EN_LO  = 25;
  localparam int unsigned CTX_W    = 6;
  localparam int unsigned XSEL_BIT = 25;
  localparam int unsigned XVAL_LO  = 26;
  localparam int unsigned XTRA_W   = CTX_W + 1;

  localparam logic [TD_W-1:0] CTRL_KEEP =
      (((32'd1 << CNT_W) - 32'd1) << CNT_LO) |
      (32'd3 << V_EN_LO) |
      (32'hB << NV_EN_LO);
  localparam logic [TD_W-1:0] CTRL_RST = {TYPE_ICNT, {(TD_W-4){1'b0}}};

  typedef enum logic [1:0] {
    CSR_SEL_NONE  = 2'd0,
    CSR_SEL_CTRL  = 2'd1,
    CSR_SEL_ADDR  = 2'd2,
    CSR_SEL_EXTRA = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/icnt_legalize.sv
module icnt_legalize
  import icnt_pkg::*;
(
  input  logic [TD_W-1:0]   raw_i,
  output logic [TD_W-1:0]   ctrl_o,
  output logic [XTRA_W-1:0] extra_o
);
  // control: type forced, unsupported fields cleared
  assign ctrl_o  = CTRL_RST | (raw_i & CTRL_KEEP);
  // context: value kept, select collapsed to off / compare
  assign extra_o = {raw_i[XVAL_LO +: CTX_W], raw_i[XSEL_BIT]};
endmodule

// File: rtl/icnt_qualify.sv
module icnt_qualify
  import icnt_pkg::*;
(
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic [3:0]       nv_en_i,
  input  logic [1:0]       v_en_i,
  input  logic             ctx_sel_i,
  input  logic [CTX_W-1:0] ctx_val_i,
  input  logic [CTX_W-1:0] mctx_i,
  output logic             ok_o
);
  logic mode_ok;
  logic ctx_ok;

  always_comb begin
    if (virt_i) mode_ok = !priv_i[1] && v_en_i[priv_i[0]];
    else        mode_ok = nv_en_i[priv_i];
  end

  assign ctx_ok = !ctx_sel_i || (ctx_val_i == mctx_i);
  assign ok_o   = mode_ok && ctx_ok;
endmodule

// File: rtl/icnt_slot.sv
module icnt_slot
  import icnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [CTX_W-1:0]  mctx_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_extra_i,
  input  logic [TD_W-1:0]   ctrl_new_i,
  input  logic [XTRA_W-1:0] extra_new_i,
  output logic [TD_W-1:0]   ctrl_o,
  output logic              hit_o,
  output logic              fire_o
);
  logic [TD_W-1:0]   ctrl_q;
  logic [XTRA_W-1:0] extra_q;
  logic              fire_q;
  logic [CNT_W-1:0]  cnt;
  logic              qual;
  logic              step;

  assign cnt = ctrl_q[CNT_LO +: CNT_W];

  icnt_qualify u_qual (
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .nv_en_i   (ctrl_q[NV_EN_LO +: 4]),
    .v_en_i    (ctrl_q[V_EN_LO +: 2]),
    .ctx_sel_i (extra_q[0]),
    .ctx_val_i (extra_q[XTRA_W-1:1]),
    .mctx_i    (mctx_i),
    .ok_o      (qual)
  );

  assign step  = retire_i && qual && (cnt != '0) && !wr_ctrl_i;
  assign hit_o = step && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      extra_q <= '0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= hit_o;
      if (wr_ctrl_i)  ctrl_q <= ctrl_new_i;
      else if (step)  ctrl_q[CNT_LO +: CNT_W] <= cnt - CNT_W'(1);
      if (wr_extra_i) extra_q <= extra_new_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign fire_o = fire_q;

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (retire_i && qual && cnt != '0 && !wr_ctrl_i) |=> cnt == $past(cnt) - CNT_W'(1));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!retire_i && !wr_ctrl_i) |=> $stable(ctrl_q));
  a_r6_dormant: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !wr_ctrl_i) |=> (cnt == '0 && !fire_q));
  a_r7_zero_on_fire: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> cnt == '0);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl_i |=> ctrl_q == $past(ctrl_new_i));
  a_r2_type: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[TYPE_LO +: 4] == TYPE_ICNT);
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      retire_i,
  input  logic [1:0]                priv_i,
  input  logic                      virt_i,
  input  logic [CTX_W-1:0]          mcontext_i,
  input  logic                      csr_we_i,
  input  logic [SLOT_W-1:0]         csr_slot_i,
  input  logic [1:0]                csr_reg_i,
  input  logic [TD_W-1:0]           csr_wdata_i,
  output logic [NUM_SLOTS*TD_W-1:0] tdata1_o,
  output logic [NUM_SLOTS-1:0]      fire_o,
  output logic                      bp_req_o
);
  logic [TD_W-1:0]      ctrl_legal;
  logic [XTRA_W-1:0]    extra_legal;
  logic [NUM_SLOTS-1:0] hit;
  logic                 bp_q;

  icnt_legalize u_legal (
    .raw_i   (csr_wdata_i),
    .ctrl_o  (ctrl_legal),
    .extra_o (extra_legal)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic sel;
    assign sel = csr_we_i && (csr_slot_i == SLOT_W'(i));

    icnt_slot u_slot (
      .clk         (clk),
      .rst         (rst),
      .retire_i    (retire_i),
      .priv_i      (priv_i),
      .virt_i      (virt_i),
      .mctx_i      (mcontext_i),
      .wr_ctrl_i   (sel && (csr_reg_i == CSR_SEL_CTRL)),
      .wr_extra_i  (sel && (csr_reg_i == CSR_SEL_EXTRA)),
      .ctrl_new_i  (ctrl_legal),
      .extra_new_i (extra_legal),
      .ctrl_o      (tdata1_o[i*TD_W +: TD_W]),
      .hit_o       (hit[i]),
      .fire_o      (fire_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bp_q <= 1'b0;
    else     bp_q <= |hit;
  end

  assign bp_req_o = bp_q;

  a_r7_bp_matches_fire: assert property (@(posedge clk) disable iff (rst)
    bp_req_o == (|fire_o));
  a_r7_fire_onehot_path: assert property (@(posedge clk) disable iff (rst)
    !bp_req_o |-> $countones(fire_o) == 0);
endmodule

// File: tb/icnt_trigger_bench.sv
module icnt_trigger_bench;
  localparam int NS = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          retire;
  logic [1:0]    priv;
  logic          virt;
  logic [5:0]    mctx;
  logic          we;
  logic [SW-1:0] wslot;
  logic [1:0]    wreg;
  logic [31:0]   wdata;
  logic [NS*32-1:0] td1;
  logic [NS-1:0] fire;
  logic          bp;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  icnt_trigger #(.NUM_SLOTS(NS)) u_icnt_trigger (
    .clk(clk), .rst(rst), .retire_i(retire), .priv_i(priv), .virt_i(virt),
    .mcontext_i(mctx), .csr_we_i(we), .csr_slot_i(wslot), .csr_reg_i(wreg),
    .csr_wdata_i(wdata), .tdata1_o(td1), .fire_o(fire), .bp_req_o(bp)
  );

  // {retire, priv, virt, expected count, expected fire}
  localparam logic [18:0] TBL [10] = '{
    {1'b1, 2'd0, 1'b0, 14'd4, 1'b0},
    {1'b1, 2'd3, 1'b0, 14'd4, 1'b0},
    {1'b0, 2'd0, 1'b0, 14'd4, 1'b0},
    {1'b1, 2'd1, 1'b0, 14'd3, 1'b0},
    {1'b1, 2'd1, 1'b1, 14'd3, 1'b0},
    {1'b1, 2'd0, 1'b1, 14'd2, 1'b0},
    {1'b1, 2'd3, 1'b1, 14'd2, 1'b0},
    {1'b1, 2'd1, 1'b0, 14'd1, 1'b0},
    {1'b1, 2'd0, 1'b0, 14'd0, 1'b1},
    {1'b1, 2'd0, 1'b0, 14'd0, 1'b0}
  };

  function automatic logic [31:0] ctl(input int s);
    return td1[s*32 +: 32];
  endfunction

  function automatic logic [31:0] cnt(input int s);
    return {18'd0, td1[s*32+10 +: 14]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input int s, input logic [1:0] r, input logic [31:0] d);
    we = 1'b1; wslot = SW'(s); wreg = r; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tick(input logic [1:0] p, input logic v);
    retire = 1'b1; priv = p; virt = v;
    @(negedge clk);
    retire = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; retire = 1'b0; priv = 2'd0; virt = 1'b0; mctx = 6'd0;
    we = 1'b0; wslot = '0; wreg = 2'd0; wdata = 32'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < NS; s++) chk("R1 ctrl", ctl(s), 32'h3000_0000);
    chk("R1 fire", {29'd0, fire}, 32'd0);
    chk("R1 bp", {31'd0, bp}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2 legalization
    csr_wr(1, 2'd1, 32'hFFFF_FFFF);
    chk("R2 all ones", ctl(1), 32'h36FF_FEC0);
    csr_wr(1, 2'd1, 32'h0000_0000);
    chk("R2 type forced", ctl(1), 32'h3000_0000);

    // R13 out-of-range slot
    csr_wr(3, 2'd1, 32'h3000_14C0);
    for (int s = 0; s < NS; s++) chk("R13 ignored", ctl(s), 32'h3000_0000);

    // table: count 5, U and S enabled, VU enabled (R3 R4 R5 R6 R7 R11)
    csr_wr(0, 2'd1, 32'h3200_14C0);
    chk("R2 load", cnt(0), 32'd5);
    for (int i = 0; i < 10; i++) begin
      retire = TBL[i][18]; priv = TBL[i][17:16]; virt = TBL[i][15];
      @(negedge clk);
      retire = 1'b0;
      chk($sformatf("R3 R4 R5 R6 R11 step%0d count", i), cnt(0), {18'd0, TBL[i][14:1]});
      chk($sformatf("R7 step%0d fire", i), {31'd0, fire[0]}, {31'd0, TBL[i][0]});
      chk($sformatf("R7 step%0d bp", i), {31'd0, bp}, {31'd0, TBL[i][0]});
    end
    virt = 1'b0;

    // R9 address write ignored, retirement still counted
    csr_wr(0, 2'd1, 32'h3000_0C40);
    we = 1'b1; wslot = 2'd0; wreg = 2'd2; wdata = 32'h1234_5678; retire = 1'b1; priv = 2'd0;
    @(negedge clk);
    we = 1'b0; retire = 1'b0;
    chk("R9 ctrl after addr write", ctl(0), 32'h3000_0840);

    // R10 write priority, R12 independence
    csr_wr(1, 2'd1, 32'h3000_0C40);
    we = 1'b1; wslot = 2'd0; wreg = 2'd1; wdata = 32'h3000_1C40; retire = 1'b1;
    @(negedge clk);
    we = 1'b0; retire = 1'b0;
    chk("R10 write wins", cnt(0), 32'd7);
    chk("R12 other slot counts", cnt(1), 32'd2);
    tick(2'd0, 1'b0);
    chk("R11 slot0", cnt(0), 32'd6);
    chk("R11 slot1", cnt(1), 32'd1);
    tick(2'd0, 1'b0);
    chk("R7 slot1 zero", cnt(1), 32'd0);
    chk("R7 fire vector", {29'd0, fire}, 32'd2);
    chk("R7 bp", {31'd0, bp}, 32'd1);
    @(negedge clk);
    chk("R7 pulse ends", {29'd0, fire}, 32'd0);
    chk("R7 bp ends", {31'd0, bp}, 32'd0);
    chk("R6 slot2 dormant", cnt(2), 32'd0);

    // R8 context qualifier, slot0 at 5
    csr_wr(0, 2'd3, 32'h5600_0000);
    mctx = 6'h0A;
    tick(2'd0, 1'b0);
    chk("R8 mismatch blocks", cnt(0), 32'd5);
    mctx = 6'h15;
    tick(2'd0, 1'b0);
    chk("R8 match counts", cnt(0), 32'd4);
    csr_wr(0, 2'd3, 32'h5680_0000);
    mctx = 6'h0A;
    tick(2'd0, 1'b0);
    chk("R8 select 5 acts as 4", cnt(0), 32'd4);
    csr_wr(0, 2'd3, 32'h5580_0000);
    tick(2'd0, 1'b0);
    chk("R8 select 3 acts as off", cnt(0), 32'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule